// File: doc/BRIEF.md
# Hart Debug-Mode Entry and Resume Controller

This block keeps the debug-mode state of one hart: a flag saying the hart is halted for debug, the saved resume address, and a compact debug control/status word. An entry pulse latches the current program counter (aligned to instruction granularity), the current privilege and virtualization state, the expected-landing-pad flag and a cause code. A resume pulse turns the saved state back into a legal return mode for the hart. It also produces the set of status bits the hart must clear and the landing-pad flag value it must restore.

Entry and resume are single-cycle control pulses with no back-pressure, so the block has no valid/ready interface. Every pulse is either accepted in its own cycle or dropped. The resume results (`rsm_*`, `clr_*`, `elp_*`) are combinational strobes that are valid only in the cycle of an accepted request. The hart applies them at the same clock edge at which the flag clears. The block also masks breakpoint and watchpoint hits while the hart is halted. Configuration pins say which optional features the hart has; they are sampled in the cycle of each request.

The status word `dcsr_rd` is 32 bits wide. Bits [1:0] hold the saved privilege, bit 2 the saved virtualization flag, bit 3 the saved landing-pad flag, and bits [6:4] the cause. All other bits read as zero. Privilege is encoded as 0 for user, 1 for supervisor and 3 for machine; the value 2 is reserved.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: While `cfg_dbg_en` is low, entry and resume requests are dropped: no strobe fires and `dbg_mode`, `dpc_rd` and `dcsr_rd` keep their values.
- R2: An accepted entry sets `dbg_mode` on the next edge and loads `dpc_rd` with `cur_pc` with bit 0 cleared when `cfg_has_c` is high, or with bits 1:0 cleared when it is low.
- R3: An accepted entry writes `cur_priv` into `dcsr_rd[1:0]` and the low three bits of `enter_cause` into `dcsr_rd[6:4]`.
- R4: An accepted entry sets `dcsr_rd[2]` only when `cur_virt` and `cfg_has_h` are both high; otherwise it clears that bit.
- R5: With `cfg_lpad_en` high, an accepted entry copies `cur_elp` into `dcsr_rd[3]` and pulses `elp_wr` with `elp_wdata` low. With `cfg_lpad_en` low, bit 3 is unchanged and `elp_wr` stays low.
- R6: On an accepted resume, `rsm_priv` equals `dcsr_rd[1:0]`, except that the value 2 becomes 3. `rsm_virt` is high only if `cfg_has_h` and `dcsr_rd[2]` are high and the target is not machine mode.
- R7: A supervisor target with `cfg_has_s` low resumes in machine mode. A user target with `cfg_has_u` low resumes in supervisor mode if `cfg_has_s` is high, otherwise in machine mode. In both cases `rsm_virt` is low.
- R8: On an accepted resume to a non-machine target, `clr_mprv` is high, and `clr_mdt` is also high if `cfg_has_mdt` is high. Both are low otherwise.
- R9: On an accepted resume with `cfg_has_sdt` high, `clr_sdt` is high when the target is user or virtualized, and `clr_vs_sdt` is high when the target is virtualized user.
- R10: With `cfg_lpad_en` high, an accepted resume pulses `elp_wr` with `elp_wdata` equal to `fcfi_en` AND `dcsr_rd[3]`, and clears `dcsr_rd[3]`.
- R11: An accepted resume pulses `rsm_valid` with `rsm_pc` equal to `dpc_rd`, and clears `dbg_mode` on the next edge. All resume strobes are low in every other cycle.
- R12: `trig_fire` equals `trig_hit` while `dbg_mode` is low and is all zero while it is high.
- R13: Entry is accepted only when `dbg_mode` is low. Resume is accepted only when `dbg_mode` is high and `enter_req` is low, so entry wins when both are asserted.
- R14: After reset, `dbg_mode`, `dpc_rd` and `dcsr_rd` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dbg_en | input | 1 | Debug feature present |
| cfg_has_c | input | 1 | Compressed instructions supported (2-byte PC alignment) |
| cfg_has_h | input | 1 | Hypervisor support present |
| cfg_has_s | input | 1 | Supervisor mode present |
| cfg_has_u | input | 1 | User mode present |
| cfg_lpad_en | input | 1 | Landing-pad tracking present |
| cfg_has_mdt | input | 1 | Machine double-trap support present |
| cfg_has_sdt | input | 1 | Supervisor double-trap support present |
| enter_req | input | 1 | Entry request pulse |
| enter_cause | input | CAUSE_IN_W | Entry cause; low 3 bits kept |
| cur_pc | input | XLEN | Current program counter |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current virtualization state |
| cur_elp | input | 1 | Current expected-landing-pad flag |
| resume_req | input | 1 | Resume request pulse |
| fcfi_en | input | 1 | Forward control-flow integrity enabled for the target |
| trig_hit | input | NTRIG | Raw trigger hits |
| dbg_mode | output | 1 | Hart is in debug mode |
| dpc_rd | output | XLEN | Saved resume address |
| dcsr_rd | output | 32 | Debug status word |
| rsm_valid | output | 1 | Resume accepted this cycle |
| rsm_pc | output | XLEN | Next PC on resume |
| rsm_priv | output | 2 | Legal resume privilege |
| rsm_virt | output | 1 | Resume virtualized |
| clr_mprv | output | 1 | Clear the modify-privilege bit |
| clr_mdt | output | 1 | Clear machine double-trap bit |
| clr_sdt | output | 1 | Clear supervisor double-trap bit |
| clr_vs_sdt | output | 1 | Clear virtual supervisor double-trap bit |
| elp_wr | output | 1 | Write the expected-landing-pad flag |
| elp_wdata | output | 1 | Value for that flag |
| trig_fire | output | NTRIG | Trigger hits allowed to act |

## Verification
The inline properties check on every cycle that the resume privilege is never the reserved code, that a machine-mode resume is never virtualized, and that the virtual supervisor double-trap clear implies the plain one. They also check that the flag rises only after an entry pulse, that state is frozen while the feature is off, that the saved address stays aligned, and that no trigger fires while halted. The bench scenarios show the value-level behaviour. This covers cause truncation, the alignment choice, the fallbacks when supervisor or user mode is absent, the landing-pad round trip, and the outcome when entry and resume collide.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam int CAUSE_FW = 3;
  localparam int DCSR_W   = 32;

  typedef struct packed {
    logic [CAUSE_FW-1:0] cause;
    logic                pelp;
    logic                virt;
    logic [1:0]          prv;
  } dcsr_t;

  localparam int DCSR_USED = $bits(dcsr_t);
endpackage

// File: rtl/dbgm_entry.sv
module dbgm_entry
  import dbgm_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_IN_W = 4
) (
  input  logic                  cfg_has_c,
  input  logic                  cfg_has_h,
  input  logic                  cfg_lpad_en,
  input  logic [XLEN-1:0]       cur_pc,
  input  logic [1:0]            cur_priv,
  input  logic                  cur_virt,
  input  logic                  cur_elp,
  input  logic [CAUSE_IN_W-1:0] cause_in,
  input  dcsr_t                 dcsr_cur,
  output logic [XLEN-1:0]       dpc_nxt,
  output dcsr_t                 dcsr_nxt
);
  localparam logic [XLEN-1:0] MASK_HALF = {{(XLEN-1){1'b1}}, 1'b0};
  localparam logic [XLEN-1:0] MASK_WORD = {{(XLEN-2){1'b1}}, 2'b00};

  logic [XLEN-1:0] align_mask;

  always_comb begin
    align_mask = cfg_has_c ? MASK_HALF : MASK_WORD;
    dpc_nxt    = cur_pc & align_mask;
  end

  always_comb begin
    dcsr_nxt       = dcsr_cur;
    dcsr_nxt.cause = cause_in[CAUSE_FW-1:0];
    dcsr_nxt.prv   = cur_priv;
    dcsr_nxt.virt  = cur_virt & cfg_has_h;
    if (cfg_lpad_en) dcsr_nxt.pelp = cur_elp;
  end
endmodule

// File: rtl/dbgm_resume.sv
module dbgm_resume
  import dbgm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  dcsr_t      dcsr_cur,
  input  logic       cfg_has_h,
  input  logic       cfg_has_s,
  input  logic       cfg_has_u,
  input  logic       cfg_has_mdt,
  input  logic       cfg_has_sdt,
  output logic [1:0] tgt_priv,
  output logic       tgt_virt,
  output logic       clr_mprv,
  output logic       clr_mdt,
  output logic       clr_sdt,
  output logic       clr_vs_sdt
);
  priv_e p_raw, p_leg;
  logic  v_leg;

  always_comb begin
    p_raw = priv_e'(dcsr_cur.prv);
    p_leg = (p_raw == PRIV_RSV) ? PRIV_M : p_raw;
    v_leg = cfg_has_h & dcsr_cur.virt & (p_leg != PRIV_M);
    if (p_leg == PRIV_S && !cfg_has_s) begin
      p_leg = PRIV_M;
      v_leg = 1'b0;
    end else if (p_leg == PRIV_U && !cfg_has_u) begin
      p_leg = cfg_has_s ? PRIV_S : PRIV_M;
      v_leg = 1'b0;
    end
  end

  always_comb begin
    tgt_priv   = 2'b00;
    tgt_virt   = 1'b0;
    clr_mprv   = 1'b0;
    clr_mdt    = 1'b0;
    clr_sdt    = 1'b0;
    clr_vs_sdt = 1'b0;
    if (go) begin
      tgt_priv   = p_leg;
      tgt_virt   = v_leg;
      clr_mprv   = (p_leg != PRIV_M);
      clr_mdt    = cfg_has_mdt & (p_leg != PRIV_M);
      clr_sdt    = cfg_has_sdt & ((p_leg == PRIV_U) | v_leg);
      clr_vs_sdt = cfg_has_sdt & v_leg & (p_leg == PRIV_U);
    end
  end

  // R6
  rsm_priv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (tgt_priv != 2'b10));
  // R6
  rsm_m_unvirt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && tgt_priv == 2'b11) |-> !tgt_virt);
  // R9
  vs_sdt_implies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vs_sdt |-> clr_sdt);
endmodule

// File: rtl/dbgm_trig_gate.sv
module dbgm_trig_gate #(
  parameter int NTRIG = 4
) (
  input  logic             halted,
  input  logic [NTRIG-1:0] hit,
  output logic [NTRIG-1:0] fire
);
  for (genvar g = 0; g < NTRIG; g++) begin : g_gate
    assign fire[g] = hit[g] & ~halted;
  end
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbgm_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_IN_W = 4,
  parameter int NTRIG      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_dbg_en,
  input  logic                  cfg_has_c,
  input  logic                  cfg_has_h,
  input  logic                  cfg_has_s,
  input  logic                  cfg_has_u,
  input  logic                  cfg_lpad_en,
  input  logic                  cfg_has_mdt,
  input  logic                  cfg_has_sdt,
  input  logic                  enter_req,
  input  logic [CAUSE_IN_W-1:0] enter_cause,
  input  logic [XLEN-1:0]       cur_pc,
  input  logic [1:0]            cur_priv,
  input  logic                  cur_virt,
  input  logic                  cur_elp,
  input  logic                  resume_req,
  input  logic                  fcfi_en,
  input  logic [NTRIG-1:0]      trig_hit,
  output logic                  dbg_mode,
  output logic [XLEN-1:0]       dpc_rd,
  output logic [31:0]           dcsr_rd,
  output logic                  rsm_valid,
  output logic [XLEN-1:0]       rsm_pc,
  output logic [1:0]            rsm_priv,
  output logic                  rsm_virt,
  output logic                  clr_mprv,
  output logic                  clr_mdt,
  output logic                  clr_sdt,
  output logic                  clr_vs_sdt,
  output logic                  elp_wr,
  output logic                  elp_wdata,
  output logic [NTRIG-1:0]      trig_fire
);
  localparam int PAD_W = DCSR_W - DCSR_USED;

  logic            dmode_q;
  logic [XLEN-1:0] dpc_q;
  dcsr_t           dcsr_q;
  logic [XLEN-1:0] dpc_nxt;
  dcsr_t           dcsr_nxt;
  logic            ent_ok;
  logic            res_ok;

  assign ent_ok = cfg_dbg_en & enter_req & ~dmode_q;
  assign res_ok = cfg_dbg_en & resume_req & ~enter_req & dmode_q;

  dbgm_entry #(.XLEN(XLEN), .CAUSE_IN_W(CAUSE_IN_W)) u_entry (
    .cfg_has_c  (cfg_has_c),
    .cfg_has_h  (cfg_has_h),
    .cfg_lpad_en(cfg_lpad_en),
    .cur_pc     (cur_pc),
    .cur_priv   (cur_priv),
    .cur_virt   (cur_virt),
    .cur_elp    (cur_elp),
    .cause_in   (enter_cause),
    .dcsr_cur   (dcsr_q),
    .dpc_nxt    (dpc_nxt),
    .dcsr_nxt   (dcsr_nxt)
  );

  dbgm_resume u_resume (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (res_ok),
    .dcsr_cur   (dcsr_q),
    .cfg_has_h  (cfg_has_h),
    .cfg_has_s  (cfg_has_s),
    .cfg_has_u  (cfg_has_u),
    .cfg_has_mdt(cfg_has_mdt),
    .cfg_has_sdt(cfg_has_sdt),
    .tgt_priv   (rsm_priv),
    .tgt_virt   (rsm_virt),
    .clr_mprv   (clr_mprv),
    .clr_mdt    (clr_mdt),
    .clr_sdt    (clr_sdt),
    .clr_vs_sdt (clr_vs_sdt)
  );

  dbgm_trig_gate #(.NTRIG(NTRIG)) u_trig (
    .halted(dmode_q),
    .hit   (trig_hit),
    .fire  (trig_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmode_q <= 1'b0;
      dpc_q   <= '0;
      dcsr_q  <= '0;
    end else if (ent_ok) begin
      dmode_q <= 1'b1;
      dpc_q   <= dpc_nxt;
      dcsr_q  <= dcsr_nxt;
    end else if (res_ok) begin
      dmode_q <= 1'b0;
      if (cfg_lpad_en) dcsr_q.pelp <= 1'b0;
    end
  end

  assign dbg_mode  = dmode_q;
  assign dpc_rd    = dpc_q;
  assign dcsr_rd   = {{PAD_W{1'b0}}, dcsr_q};
  assign rsm_valid = res_ok;
  assign rsm_pc    = res_ok ? dpc_q : '0;
  assign elp_wr    = (ent_ok | res_ok) & cfg_lpad_en;
  assign elp_wdata = res_ok & cfg_lpad_en & fcfi_en & dcsr_q.pelp;

  // R13
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dmode_q) |-> $past(enter_req && cfg_dbg_en));
  // R1
  off_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dbg_en |=> ($stable(dmode_q) && $stable(dpc_q) && $stable(dcsr_q)));
  // R11
  resume_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsm_valid |=> !dmode_q);
  // R2
  dpc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmode_q |-> (dpc_q[0] == 1'b0));
  // R12
  halted_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmode_q |-> (trig_fire == '0));
endmodule

// File: tb/test_dbg_mode_ctrl.sv
module test_dbg_mode_ctrl;
  localparam int XLEN = 32;
  localparam int CIW  = 4;
  localparam int NT   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_dbg_en = 0, cfg_has_c = 0, cfg_has_h = 0, cfg_has_s = 0, cfg_has_u = 0;
  logic cfg_lpad_en = 0, cfg_has_mdt = 0, cfg_has_sdt = 0;
  logic enter_req = 0, resume_req = 0, cur_virt = 0, cur_elp = 0, fcfi_en = 0;
  logic [CIW-1:0]  enter_cause = '0;
  logic [XLEN-1:0] cur_pc = '0;
  logic [1:0]      cur_priv = '0;
  logic [NT-1:0]   trig_hit = '0;

  logic            dbg_mode, rsm_valid, rsm_virt, clr_mprv, clr_mdt, clr_sdt, clr_vs_sdt;
  logic            elp_wr, elp_wdata;
  logic [XLEN-1:0] dpc_rd, rsm_pc;
  logic [31:0]     dcsr_rd;
  logic [1:0]      rsm_priv;
  logic [NT-1:0]   trig_fire;

  dbg_mode_ctrl #(.XLEN(XLEN), .CAUSE_IN_W(CIW), .NTRIG(NT)) i_dbg_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_dbg_en(cfg_dbg_en), .cfg_has_c(cfg_has_c),
    .cfg_has_h(cfg_has_h), .cfg_has_s(cfg_has_s), .cfg_has_u(cfg_has_u),
    .cfg_lpad_en(cfg_lpad_en), .cfg_has_mdt(cfg_has_mdt), .cfg_has_sdt(cfg_has_sdt),
    .enter_req(enter_req), .enter_cause(enter_cause), .cur_pc(cur_pc),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .cur_elp(cur_elp),
    .resume_req(resume_req), .fcfi_en(fcfi_en), .trig_hit(trig_hit),
    .dbg_mode(dbg_mode), .dpc_rd(dpc_rd), .dcsr_rd(dcsr_rd), .rsm_valid(rsm_valid),
    .rsm_pc(rsm_pc), .rsm_priv(rsm_priv), .rsm_virt(rsm_virt), .clr_mprv(clr_mprv),
    .clr_mdt(clr_mdt), .clr_sdt(clr_sdt), .clr_vs_sdt(clr_vs_sdt),
    .elp_wr(elp_wr), .elp_wdata(elp_wdata), .trig_fire(trig_fire)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  logic            m_dm = 0;
  logic [XLEN-1:0] m_dpc = '0;
  logic [2:0]      m_cause = '0;
  logic            m_pelp = 0, m_v = 0;
  logic [1:0]      m_prv = '0;
  string           st_tag = "R13";

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // {virt, priv} from the resume rules (R6, R7)
  function automatic logic [2:0] leg(input logic [1:0] p, input logic v,
                                     input logic h, input logic s, input logic u);
    logic [1:0] q;
    logic       w;
    q = (p == 2'd2) ? 2'd3 : p;
    w = h & v & (q != 2'd3);
    if (q == 2'd1 && !s) begin q = 2'd3; w = 1'b0; end
    else if (q == 2'd0 && !u) begin q = s ? 2'd1 : 2'd3; w = 1'b0; end
    return {w, q};
  endfunction

  // One cycle: inputs are already set (driven after a negedge)
  task automatic run_cycle();
    logic       a_ent, a_res;
    logic [2:0] lg;
    logic [1:0] ep;
    logic       ev;
    #1;
    // registered state vs model
    chk({st_tag, "/R14 dbg_mode"}, dbg_mode, m_dm);
    chk({st_tag, "/R2 dpc"}, dpc_rd, m_dpc);
    chk({st_tag, "/R3 dcsr prv+cause"}, {dcsr_rd[31:7], dcsr_rd[6:4], dcsr_rd[1:0]},
        {25'd0, m_cause, m_prv});
    chk({st_tag, "/R4 dcsr v"}, dcsr_rd[2], m_v);
    chk({st_tag, "/R5 dcsr pelp"}, dcsr_rd[3], m_pelp);
    a_ent = cfg_dbg_en & enter_req & ~m_dm;
    a_res = cfg_dbg_en & resume_req & ~enter_req & m_dm;
    lg = leg(m_prv, m_v, cfg_has_h, cfg_has_s, cfg_has_u);
    ep = a_res ? lg[1:0] : 2'd0;
    ev = a_res & lg[2];
    chk("R11/R13 rsm_valid", rsm_valid, a_res);
    chk("R11 rsm_pc", rsm_pc, a_res ? m_dpc : '0);
    chk((m_prv == 2'd0 && !cfg_has_u) || (m_prv == 2'd1 && !cfg_has_s) ? "R7 rsm_priv" : "R6 rsm_priv",
        rsm_priv, ep);
    chk("R6 rsm_virt", rsm_virt, ev);
    chk("R8 clr_mprv", clr_mprv, a_res & (ep != 2'd3));
    chk("R8 clr_mdt", clr_mdt, a_res & cfg_has_mdt & (ep != 2'd3));
    chk("R9 clr_sdt", clr_sdt, a_res & cfg_has_sdt & ((ep == 2'd0) | ev));
    chk("R9 clr_vs_sdt", clr_vs_sdt, a_res & cfg_has_sdt & ev & (ep == 2'd0));
    chk("R5/R10 elp_wr", elp_wr, (a_ent | a_res) & cfg_lpad_en);
    chk("R10 elp_wdata", elp_wdata, a_res & cfg_lpad_en & fcfi_en & m_pelp);
    chk("R12 trig_fire", trig_fire, m_dm ? '0 : trig_hit);
    st_tag = (!cfg_dbg_en && (enter_req || resume_req)) ? "R1" : "R13";
    @(posedge clk);
    if (a_ent) begin
      m_dm = 1;
      m_dpc = cur_pc & (cfg_has_c ? ~32'd1 : ~32'd3);
      m_cause = enter_cause[2:0];
      m_prv = cur_priv;
      m_v = cur_virt & cfg_has_h;
      if (cfg_lpad_en) m_pelp = cur_elp;
    end else if (a_res) begin
      m_dm = 0;
      if (cfg_lpad_en) m_pelp = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    enter_req = 0; resume_req = 0;
  endtask

  task automatic cfg_all(input logic h, input logic s, input logic u);
    cfg_dbg_en = 1; cfg_has_h = h; cfg_has_s = s; cfg_has_u = u;
    cfg_has_mdt = 1; cfg_has_sdt = 1; cfg_lpad_en = 1;
  endtask

  initial begin
    void'($urandom(32'h5EED_D0C7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R14 reset state and R1 disabled feature
    idle(); run_cycle();
    cfg_dbg_en = 0; enter_req = 1; cur_pc = 32'h1234; cur_priv = 2'd3; run_cycle();
    idle(); run_cycle();
    // R3 cause truncation, reserved priv, R2 word alignment
    cfg_all(1, 1, 1); cfg_has_c = 0;
    enter_req = 1; enter_cause = 4'hD; cur_pc = 32'h8000_0007; cur_priv = 2'd2;
    cur_virt = 1; cur_elp = 1; trig_hit = 4'hF; run_cycle();
    // R13: both requests while halted -> nothing; R12 triggers masked
    enter_req = 1; resume_req = 1; run_cycle();
    idle(); resume_req = 1; fcfi_en = 1; run_cycle();   // R6 reserved -> M, R10
    idle(); resume_req = 1; run_cycle();                 // R13 resume while running ignored
    // R7 supervisor absent
    idle(); cfg_has_c = 1; enter_req = 1; cur_priv = 2'd1; cur_virt = 1; cur_pc = 32'h33;
    run_cycle();
    idle(); cfg_has_s = 0; resume_req = 1; run_cycle();
    // R7 user absent, supervisor present and absent
    idle(); cfg_all(1, 1, 1); enter_req = 1; cur_priv = 2'd0; cur_virt = 1; run_cycle();
    idle(); cfg_has_u = 0; resume_req = 1; run_cycle();
    idle(); cfg_all(1, 1, 1); enter_req = 1; run_cycle();
    idle(); cfg_has_u = 0; cfg_has_s = 0; resume_req = 1; run_cycle();
    // R9 virtualized user resume
    idle(); cfg_all(1, 1, 1); enter_req = 1; cur_priv = 2'd0; cur_virt = 1; run_cycle();
    idle(); resume_req = 1; run_cycle();
    // R1 disabled resume while halted
    idle(); enter_req = 1; run_cycle();
    idle(); cfg_dbg_en = 0; resume_req = 1; run_cycle();
    idle(); cfg_dbg_en = 1; resume_req = 1; run_cycle();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      cfg_dbg_en  = ($urandom % 10) != 0;
      cfg_has_c   = $urandom; cfg_has_h = $urandom; cfg_has_s = $urandom;
      cfg_has_u   = $urandom; cfg_lpad_en = $urandom;
      cfg_has_mdt = $urandom; cfg_has_sdt = $urandom;
      enter_req   = ($urandom % 4) == 0;
      resume_req  = ($urandom % 3) == 0;
      enter_cause = $urandom; cur_pc = $urandom; cur_priv = $urandom;
      cur_virt    = $urandom; cur_elp = $urandom; fcfi_en = $urandom;
      trig_hit    = $urandom;
      run_cycle();
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule